// File: doc/BRIEF.md
# Time-Multiplexed Wavetable Oscillator Bank

This block runs sixteen independent digital oscillators on a single shared datapath. A minor-cycle counter picks one voice on each clock cycle. In that cycle the block reads the voice's frequency word and phase, adds them modulo 2^20, and writes the new phase back. It then uses the top six phase bits to read one entry from that voice's own waveform table. Sixteen minor cycles make one major cycle, so each voice produces one sample per major cycle. The computation rate is sixteen times the per-voice sample rate.

Each voice owns two table banks. The host fills the bank that is not playing and then asks for a swap. The swap waits until that voice's phase wraps, so a waveform never changes part-way through a period.

The host uses a single write port with a region select. This port has valid/ready, but ready is always high: a write is taken in the cycle it is presented and never stalls the voice sequence. The sample output has only a valid strobe. It produces one sample every cycle at a fixed rate and accepts no back-pressure, so a consumer must take every sample.

Top module: `wavebank_mux`

## Requirements
- R1: While reset is held, out_valid is low. Reset clears all phases and frequency words and selects bank 0 with no swap pending for every voice.
- R2: The voice served advances by one each clock cycle, 0 to 15, then returns to 0. out_voice follows the same order.
- R3: From the first clock edge after reset is released, out_valid is high on every cycle. Each sample appears one cycle after its voice is served.
- R4: On each visit, a voice's phase grows by its frequency word modulo 2^20. The table index is bits [19:14] of the new phase, so a frequency word of 0 holds the index steady.
- R5: out_sample is the 12-bit signed entry at table[out_voice][bank in use][index].
- R6: A write with wr_sel = 0 loads wr_data[19:0] into the frequency word of wr_voice. Voices keep separate frequency words. A write with wr_sel = 3 has no effect.
- R7: A write with wr_sel = 1 stores wr_data[11:0] at entry wr_addr of the bank of wr_voice that is not in use. It has no effect on the output until a swap.
- R8: A write with wr_sel = 2 makes a swap pending for wr_voice. The bank flips on that voice's first later visit whose phase addition carries out of bit 19. The sample from that visit already comes from the new bank. The pending flag then clears, so later wraps do not flip the bank again.
- R9: wr_ready is always high, and host writes of any region never interrupt or shift the voice sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one minor cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Always high; write accepted the same cycle |
| wr_sel | input | 2 | Region: 0 frequency, 1 table entry, 2 swap request, 3 none |
| wr_voice | input | 4 | Voice targeted by the write |
| wr_addr | input | 6 | Table entry index for region 1 |
| wr_data | input | 20 | Frequency word, or table sample in bits [11:0] |
| out_valid | output | 1 | Sample strobe, high every cycle after reset |
| out_voice | output | 4 | Voice that produced out_sample |
| out_sample | output | 12 | Signed waveform sample |

## Verification
The assertions check on every cycle that the minor counter steps in order and that the output strobe stays continuous with consecutive voice tags. They also check, for each voice, that a bank flip is always paired with a pending swap being consumed. Several behaviours depend on table contents and long stretches of visits, so only the bench scenarios can show them. These are the correct index step for whole and fractional frequency words, the independence of the voices, a write to the idle bank having no effect on the output, and the exact visit on which a swap takes hold.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_TABLE = 2'd1,
    SEL_SWAP  = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/wb_seq.sv
module wb_seq #(
  parameter int VOICES = 16,
  localparam int VW = $clog2(VOICES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [VW-1:0] slot
);
  localparam logic [VW-1:0] LAST = VW'(VOICES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)            slot <= '0;
    else if (slot == LAST) slot <= '0;
    else                   slot <= slot + 1'b1;
  end

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1));
  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST) |=> (slot == '0));
endmodule

// File: rtl/wb_state.sv
module wb_state #(
  parameter int VOICES = 16,
  parameter int FW     = 20,
  parameter int TAW    = 6,
  localparam int VW = $clog2(VOICES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [VW-1:0]  slot,
  input  logic           fw_en,
  input  logic           sw_en,
  input  logic [VW-1:0]  hv,
  input  logic [FW-1:0]  hdata,
  output logic [TAW-1:0] lk_addr,
  output logic           lk_bank,
  output logic           wr_bank
);
  logic [FW-1:0]     ph_q   [VOICES];
  logic [FW-1:0]     freq_q [VOICES];
  logic [VOICES-1:0] act_q, pend_q;
  logic [VOICES-1:0] clr_v, set_v;
  logic [FW:0]       sum;
  logic              wrap, flip;

  assign sum     = {1'b0, ph_q[slot]} + {1'b0, freq_q[slot]};
  assign wrap    = sum[FW];
  assign flip    = wrap & pend_q[slot];
  assign lk_addr = sum[FW-1 -: TAW];
  assign lk_bank = act_q[slot] ^ flip;
  assign wr_bank = ~act_q[hv];

  always_comb begin
    clr_v = '0;
    set_v = '0;
    clr_v[slot] = flip;
    set_v[hv]   = sw_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < VOICES; i++) begin
        ph_q[i]   <= '0;
        freq_q[i] <= '0;
      end
      act_q  <= '0;
      pend_q <= '0;
    end else begin
      ph_q[slot] <= sum[FW-1:0];
      if (fw_en) freq_q[hv] <= hdata;
      act_q  <= act_q ^ clr_v;
      pend_q <= (pend_q & ~clr_v) | set_v;
    end
  end

  for (genvar g = 0; g < VOICES; g++) begin : g_chk
    // R8
    pend_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[g]) |-> !$stable(act_q[g]));
    // R8
    bank_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q[g]) |-> $past(pend_q[g]));
  end
endmodule

// File: rtl/wb_table.sv
module wb_table #(
  parameter int VOICES = 16,
  parameter int TAW    = 6,
  parameter int SW     = 12,
  localparam int VW    = $clog2(VOICES),
  localparam int IW    = VW + 1 + TAW,
  localparam int DEPTH = VOICES * 2 * (1 << TAW)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [VW-1:0]  wv,
  input  logic           wb,
  input  logic [TAW-1:0] wa,
  input  logic [SW-1:0]  wd,
  input  logic [VW-1:0]  rv,
  input  logic           rb,
  input  logic [TAW-1:0] ra,
  output logic [SW-1:0]  rd
);
  logic [SW-1:0] mem [DEPTH];
  logic [IW-1:0] widx, ridx;

  assign widx = {wv, wb, wa};
  assign ridx = {rv, rb, ra};

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wd;
    rd <= mem[ridx];
  end
endmodule

// File: rtl/wavebank_mux.sv
module wavebank_mux import wb_pkg::*; #(
  parameter int VOICES = 16,
  parameter int FW     = 20,
  parameter int TAW    = 6,
  parameter int SW     = 12,
  localparam int VW = $clog2(VOICES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [1:0]           wr_sel,
  input  logic [VW-1:0]        wr_voice,
  input  logic [TAW-1:0]       wr_addr,
  input  logic [FW-1:0]        wr_data,
  output logic                 out_valid,
  output logic [VW-1:0]        out_voice,
  output logic signed [SW-1:0] out_sample
);
  wsel_e          sel;
  logic           fw_en, sw_en, tw_en;
  logic [VW-1:0]  slot;
  logic [TAW-1:0] lk_addr;
  logic           lk_bank, wr_bank;
  logic [SW-1:0]  rd;

  assign sel      = wsel_e'(wr_sel);
  assign wr_ready = 1'b1;
  assign fw_en    = wr_valid && (sel == SEL_FREQ);
  assign tw_en    = wr_valid && (sel == SEL_TABLE);
  assign sw_en    = wr_valid && (sel == SEL_SWAP);

  wb_seq #(.VOICES(VOICES)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot(slot)
  );

  wb_state #(.VOICES(VOICES), .FW(FW), .TAW(TAW)) u_state (
    .clk(clk), .rst_n(rst_n), .slot(slot),
    .fw_en(fw_en), .sw_en(sw_en), .hv(wr_voice), .hdata(wr_data),
    .lk_addr(lk_addr), .lk_bank(lk_bank), .wr_bank(wr_bank)
  );

  wb_table #(.VOICES(VOICES), .TAW(TAW), .SW(SW)) u_tbl (
    .clk(clk),
    .we(tw_en), .wv(wr_voice), .wb(wr_bank), .wa(wr_addr), .wd(wr_data[SW-1:0]),
    .rv(slot), .rb(lk_bank), .ra(lk_addr), .rd(rd)
  );

  assign out_sample = rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_voice <= '0;
    end else begin
      out_valid <= 1'b1;
      out_voice <= slot;
    end
  end

  // R3
  valid_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
  // R2
  voice_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      (out_voice == (($past(out_voice) == VW'(VOICES - 1)) ? '0 : $past(out_voice) + 1'b1)));
  // R3
  voice_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_voice == $past(slot)));
endmodule

// File: tb/test_wavebank_mux.sv
module test_wavebank_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_sel = 2'd3;
  logic [3:0]  wr_voice = '0;
  logic [5:0]  wr_addr = '0;
  logic [19:0] wr_data = '0;
  logic        out_valid;
  logic [3:0]  out_voice;
  logic signed [11:0] out_sample;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 0;
  bit mon_first = 1;
  int mon_err = 0;
  int mon_n = 0;
  logic [3:0] mon_prev = '0;

  always #2 clk = ~clk;

  wavebank_mux i_wavebank_mux (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel),
    .wr_voice(wr_voice), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_voice(out_voice), .out_sample(out_sample)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // sequence monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      mon_n++;
      if (!out_valid) mon_err++;
      else if (!mon_first && out_voice != 4'(mon_prev + 1)) mon_err++;
      mon_prev  = out_voice;
      mon_first = 0;
    end
  end

  task automatic hw(input logic [1:0] s, input logic [3:0] v,
                    input logic [5:0] a, input logic [19:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = s; wr_voice = v; wr_addr = a; wr_data = d;
  endtask

  task automatic hw_idle();
    @(negedge clk);
    wr_valid = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic get_sample(input logic [3:0] v, output logic [11:0] s);
    do @(negedge clk); while (!(out_valid && out_voice == v));
    s = out_sample;
  endtask

  function automatic logic [11:0] enc(input bit b, input logic [3:0] v, input logic [5:0] a);
    return {1'b0, b, v, a};
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(wr_ready == 1'b1, "R9", "wr_ready in reset", wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R3", "valid one cycle after reset", out_valid, 1);
    chk(out_voice == 4'd0, "R2", "first voice", out_voice, 0);
  endtask

  // load idle bank 1 for all voices during live running, then swap all
  task automatic t_load_swap_all();
    logic [11:0] s;
    mon_first = 1; mon_err = 0; mon_n = 0; mon_on = 1;
    for (int v = 0; v < 16; v++)
      for (int a = 0; a < 64; a++)
        hw(2'd1, 4'(v), 6'(a), 20'(enc(1'b1, 4'(v), 6'(a))));
    for (int v = 0; v < 16; v++) hw(2'd0, 4'(v), '0, 20'h80000);
    for (int v = 0; v < 16; v++) hw(2'd2, 4'(v), '0, '0);
    hw_idle();
    mon_on = 0;
    chk(mon_err == 0 && mon_n > 1000, "R9", "sequence during writes", mon_err, 0);
    chk(wr_ready == 1'b1, "R9", "wr_ready after writes", wr_ready, 1);
    repeat (80) @(negedge clk);
    for (int v = 0; v < 16; v += 5) begin
      get_sample(4'(v), s);
      chk(s[10] == 1'b1, "R8", "bank after swap with wraps", s[10], 1);
      chk(s[9:6] == 4'(v), "R5", "voice field", s[9:6], v);
    end
    // bank 1 entries at phase 0 / 0x80000 → index 0 or 32
    get_sample(4'd2, s);
    chk(s[5:0] == 6'd0 || s[5:0] == 6'd32, "R4", "half-cycle index", s[5:0], 0);
  endtask

  task automatic step_chk(input logic [3:0] v, input int k, input string req);
    logic [11:0] s0, s1;
    get_sample(v, s0);
    get_sample(v, s1);
    chk(6'(s1[5:0] - s0[5:0]) == 6'(k), req, $sformatf("step voice %0d", v),
        6'(s1[5:0] - s0[5:0]), k);
    chk(s1[9:6] == v && s1[10] == 1'b1, "R5", "table entry source", s1[10:6], 16 + v);
  endtask

  task automatic t_freqs();
    logic [11:0] a0, a1, a2;
    hw(2'd0, 4'd0, '0, 20'd0);
    hw(2'd0, 4'd1, '0, 20'(1 << 14));
    hw(2'd0, 4'd2, '0, 20'(7 << 14));
    hw(2'd0, 4'd5, '0, 20'(40 << 14));
    hw(2'd0, 4'd6, '0, 20'(3 << 13));
    hw(2'd3, 4'd1, '0, 20'(9 << 14));   // region 3: ignored
    hw_idle();
    repeat (40) @(negedge clk);
    step_chk(4'd0, 0, "R4");
    step_chk(4'd1, 1, "R6");
    step_chk(4'd2, 7, "R6");
    step_chk(4'd5, 40, "R4");
    step_chk(4'd5, 40, "R4");
    get_sample(4'd6, a0);
    get_sample(4'd6, a1);
    get_sample(4'd6, a2);
    chk(6'(a2[5:0] - a0[5:0]) == 6'd3, "R4", "fractional step over two visits",
        6'(a2[5:0] - a0[5:0]), 3);
  endtask

  task automatic t_swap_one();
    logic [11:0] s, prev;
    bit flipped;
    int bad;
    hw(2'd0, 4'd3, '0, 20'(5 << 14));
    for (int a = 0; a < 64; a++) hw(2'd1, 4'd3, 6'(a), 20'(12'h800 | a));
    hw_idle();
    repeat (40) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      get_sample(4'd3, s);
      if (s[11] || s[10] != 1'b1) bad++;
    end
    chk(bad == 0, "R7", "idle bank write not visible", bad, 0);
    for (int a = 0; a < 64; a++) hw(2'd1, 4'd3, 6'(a), 20'(enc(1'b0, 4'd3, 6'(a))));
    hw(2'd2, 4'd3, '0, '0);
    hw_idle();
    get_sample(4'd3, prev);
    flipped = 0;
    for (int i = 0; i < 40 && !flipped; i++) begin
      get_sample(4'd3, s);
      if (s[10] == 1'b0) begin
        flipped = 1;
        chk(prev[10] == 1'b1, "R8", "bank before flip", prev[10], 1);
        chk(s[5:0] < prev[5:0], "R8", "flip only on wrap", s[5:0], prev[5:0]);
        chk(s[5:0] == 6'(prev[5:0] + 5), "R8", "index at flip", s[5:0], 6'(prev[5:0] + 5));
        chk(s[11] == 1'b0, "R7", "rewritten entry used", s[11], 0);
      end else if (s[5:0] < prev[5:0]) begin
        chk(0, "R8", "wrap without flip", s[5:0], prev[5:0]);
      end
      prev = s;
    end
    chk(flipped, "R8", "swap took effect", flipped, 1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      get_sample(4'd3, s);
      if (s[10] != 1'b0) bad++;
    end
    chk(bad == 0, "R8", "no second flip", bad, 0);
    step_chk(4'd1, 1, "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_load_swap_all();
    t_freqs();
    t_swap_one();
    finish_run();
  end
endmodule